// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Guard

This block keeps the status byte of a serial flash device and rules on every write-type request before it reaches the array. It holds a volatile busy flag and a write-enable latch, plus two protection-level bits and a status-lock bit that a real device would keep in non-volatile cells. A command decoder in front of it raises one-cycle strobes for write-enable, write-disable, status write, page program, sector erase and full-array erase, together with the target address and the new status byte. One cycle later the block answers each program, erase or status-write strobe with either a grant pulse or a deny pulse, and it updates the status byte.

The block also times the internal operation that follows a grant. The busy flag stays high for a parameterised number of cycles per operation kind. A device controller reads the status byte to poll for completion. It uses the grant pulses to start the array operation.

Top module: `flash_sr_guard`

## Requirements
- R1: The status byte reads bit0 = busy, bit1 = write-enable latch, bits 3:2 = protection level, bit7 = status lock, and bits 6:4 always 0. After reset the byte is 0x00.
- R2: When the block is idle, a write-enable strobe sets the latch and a write-disable strobe clears it, visible in the cycle after the strobe.
- R3: A status-write, program, sector-erase or full-erase strobe seen while the latch is 0 is denied. Grant and deny vectors use bit0 = status write, bit1 = program, bit2 = sector erase, bit3 = full erase. The response pulses for one cycle, the cycle after the strobe.
- R4: A granted request pulses its grant bit in the cycle after the strobe. Busy is then high for exactly WRSR_CYC, PP_CYC, SE_CYC or BE_CYC cycles, depending on the request. The latch clears in the same cycle that busy falls.
- R5: A denied request that arrives while idle clears the latch in the cycle after the strobe and does not raise busy.
- R6: Program and sector erase are denied when the address lies in the protected region. Level 00 protects nothing. Level 01 protects addresses whose two top bits are 11. Level 10 protects addresses whose top bit is 1. Level 11 protects everything.
- R7: Full-array erase is denied whenever the protection level is not 00.
- R8: A granted status write takes the protection level from data bits 3:2 and the lock from data bit 7 in the cycle after the strobe. All other data bits are ignored.
- R9: While the lock is 1 and the active-low protect pin is 0, status writes are denied and the lock and level do not change. With the pin at 1, or the lock at 0, status writes obey R3 and R8.
- R10: While busy, a request strobe gets a deny pulse and changes no state. Write-enable and write-disable strobes are ignored.
- R11: If several strobes arrive in one cycle, only the highest is acted on. The order, highest first, is: status write, program, sector erase, full erase, write-enable, write-disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_pp | input | 1 | Page-program strobe |
| cmd_se | input | 1 | Sector-erase strobe |
| cmd_be | input | 1 | Full-array erase strobe |
| cmd_addr | input | ADDR_W | Target address for program and sector erase |
| wrsr_data | input | 8 | New status byte for a status write |
| status | output | 8 | Status byte |
| op_grant | output | 4 | Grant pulses, one bit per request kind |
| op_deny | output | 4 | Deny pulses, one bit per request kind |

## Verification
Every result is registered once. Grant and deny pulses, latch changes and new protection bits appear in the cycle after the strobe. Busy rises in that same cycle and falls exactly the operation length later, together with the latch. The bench drives strobes on the falling edge and advances its behavioural model on the rising edge. It compares the whole status byte and both response vectors on every falling edge, so each result is checked in exactly the cycle it is due. Directed checks at the same falling edge confirm the hand-computed pulses for the protection corner cases.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam int OP_N    = 4;
  localparam int OP_WRSR = 0;
  localparam int OP_PP   = 1;
  localparam int OP_SE   = 2;
  localparam int OP_BE   = 3;

  typedef logic [OP_N-1:0] op_vec_t;
  typedef logic [1:0]      prot_lvl_t;

  localparam prot_lvl_t LVL_NONE    = 2'b00;
  localparam prot_lvl_t LVL_QUARTER = 2'b01;
  localparam prot_lvl_t LVL_HALF    = 2'b10;
  localparam prot_lvl_t LVL_ALL     = 2'b11;
endpackage

// File: rtl/sr_region_check.sv
module sr_region_check
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  prot_lvl_t         lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (lvl)
      LVL_NONE:    hit = 1'b0;
      LVL_QUARTER: hit = addr[TOP] & addr[TOP-1];
      LVL_HALF:    hit = addr[TOP];
      default:     hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_busy_timer.sv
module sr_busy_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign busy   = (cnt_q != '0);
  assign last   = (cnt_q == CNT_W'(1));
  assign cnt_en = load | busy;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_len;
    else if (busy) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R10
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int WRSR_CYC = 6,
  parameter int PP_CYC   = 10,
  parameter int SE_CYC   = 16,
  parameter int BE_CYC   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        wrsr_data,
  output logic [7:0]        status,
  output logic [3:0]        op_grant,
  output logic [3:0]        op_deny
);
  localparam int MAX_A = (WRSR_CYC > PP_CYC) ? WRSR_CYC : PP_CYC;
  localparam int MAX_B = (SE_CYC > BE_CYC) ? SE_CYC : BE_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int OP_LEN [OP_N] = '{WRSR_CYC, PP_CYC, SE_CYC, BE_CYC};

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // state
  logic      wel_q, wel_d, wel_en;
  prot_lvl_t lvl_q, lvl_d;
  logic      lock_q, lock_d, sr_en;
  op_vec_t   grant_q, grant_d, deny_q, deny_d;

  // request decode
  op_vec_t          req, sel, ok;
  logic             any_op, hw_lock, region_hit;
  logic             busy, busy_last;
  logic [CNT_W-1:0] len_d;
  logic             unused_data_bits;

  assign unused_data_bits = ^{wrsr_data[6:4], wrsr_data[1:0]};

  always_comb begin
    req               = '0;
    req[OP_WRSR]      = cmd_wrsr;
    req[OP_PP]        = cmd_pp;
    req[OP_SE]        = cmd_se;
    req[OP_BE]        = cmd_be;
  end

  // lowest index wins: status write, program, sector erase, full erase
  always_comb begin
    sel = '0;
    for (int i = OP_N - 1; i >= 0; i--) begin
      if (req[i]) sel = op_vec_t'(1) << i;
    end
  end

  assign any_op  = |req;
  assign hw_lock = lock_q & ~wp_n;

  sr_region_check #(.ADDR_W(ADDR_W)) u_region (
    .lvl  (lvl_q),
    .addr (cmd_addr),
    .hit  (region_hit)
  );

  always_comb begin
    ok          = '0;
    ok[OP_WRSR] = wel_q & ~hw_lock;
    ok[OP_PP]   = wel_q & ~region_hit;
    ok[OP_SE]   = wel_q & ~region_hit;
    ok[OP_BE]   = wel_q & (lvl_q == LVL_NONE);
  end

  assign grant_d = sel & ok & {OP_N{~busy}};
  assign deny_d  = sel & ~grant_d;

  always_comb begin
    len_d = '0;
    for (int i = 0; i < OP_N; i++) begin
      if (sel[i]) len_d = CNT_W'(OP_LEN[i]);
    end
  end

  sr_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (|grant_d),
    .load_len (len_d),
    .busy     (busy),
    .last     (busy_last)
  );

  // write-enable latch next state
  always_comb begin
    wel_d = wel_q;
    if (busy) begin
      if (busy_last) wel_d = 1'b0;
    end else if (any_op) begin
      if (~|grant_d) wel_d = 1'b0;
    end else if (cmd_wren) begin
      wel_d = 1'b1;
    end else if (cmd_wrdi) begin
      wel_d = 1'b0;
    end
  end
  assign wel_en = (wel_d != wel_q);

  // protection bits next state
  assign sr_en  = grant_d[OP_WRSR];
  assign lvl_d  = wrsr_data[3:2];
  assign lock_d = wrsr_data[7];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wel_q <= 1'b0;
    end else if (wel_en) begin
      wel_q <= wel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lvl_q  <= LVL_NONE;
      lock_q <= 1'b0;
    end else if (sr_en) begin
      lvl_q  <= lvl_d;
      lock_q <= lock_d;
    end
  end

  for (genvar g = 0; g < OP_N; g++) begin : g_resp
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        grant_q[g] <= 1'b0;
        deny_q[g]  <= 1'b0;
      end else begin
        grant_q[g] <= grant_d[g];
        deny_q[g]  <= deny_d[g];
      end
    end
  end

  assign status   = {lock_q, 3'b000, lvl_q, wel_q, busy};
  assign op_grant = grant_q;
  assign op_deny  = deny_q;

  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|grant_q) |-> $past(wel_q)); // R3
  AST_GRANT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|grant_q) |-> busy); // R4
  AST_DENY_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((|deny_q) && !$past(busy)) |-> !wel_q); // R5
  AST_BE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    grant_q[OP_BE] |-> ($past(lvl_q) == LVL_NONE)); // R7
  AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lock_q && !wp_n) |=> $stable({lock_q, lvl_q})); // R9
  AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|grant_q) |-> !$past(busy)); // R10
  AST_SINGLE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({grant_q, deny_q})); // R11
endmodule

// File: tb/flash_sr_guard_test.sv
module flash_sr_guard_test;
  localparam int ADDR_W   = 17;
  localparam int WRSR_CYC = 6;
  localparam int PP_CYC   = 10;
  localparam int SE_CYC   = 16;
  localparam int BE_CYC   = 24;
  localparam int MEM_SZ   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wp_n = 1'b1;
  logic              cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0;
  logic              cmd_pp = 0, cmd_se = 0, cmd_be = 0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [7:0]        wrsr_data = '0;
  logic [7:0]        status;
  logic [3:0]        op_grant, op_deny;

  always #2 clk = ~clk; // 250 MHz

  flash_sr_guard #(.ADDR_W(ADDR_W), .WRSR_CYC(WRSR_CYC), .PP_CYC(PP_CYC),
                   .SE_CYC(SE_CYC), .BE_CYC(BE_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be),
    .cmd_addr(cmd_addr), .wrsr_data(wrsr_data),
    .status(status), .op_grant(op_grant), .op_deny(op_deny));

  int n_checks = 0, n_fail = 0;
  bit live = 0, done = 0;

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // behavioural reference model
  int   m_left = 0;
  bit   m_wel = 0, m_lock = 0;
  int   m_lvl = 0;
  int   m_grant = 0, m_deny = 0;

  function automatic int op_len(int op);
    case (op)
      0: return WRSR_CYC;
      1: return PP_CYC;
      2: return SE_CYC;
      default: return BE_CYC;
    endcase
  endfunction

  function automatic bit in_region(int lvl, int addr);
    int limit;
    case (lvl)
      0: limit = MEM_SZ;
      1: limit = (MEM_SZ / 4) * 3;
      2: limit = MEM_SZ / 2;
      default: limit = 0;
    endcase
    return addr >= limit;
  endfunction

  always @(posedge clk) begin
    int  op;
    bit  ok;
    if (!rst_n) begin
      m_left = 0; m_wel = 0; m_lock = 0; m_lvl = 0; m_grant = 0; m_deny = 0;
    end else begin
      m_grant = 0; m_deny = 0;
      op = cmd_wrsr ? 0 : cmd_pp ? 1 : cmd_se ? 2 : cmd_be ? 3 : -1;
      if (m_left > 0) begin
        if (op >= 0) m_deny = 1 << op;
        m_left--;
        if (m_left == 0) m_wel = 0;
      end else if (op >= 0) begin
        case (op)
          0: ok = m_wel && !(m_lock && !wp_n);
          1, 2: ok = m_wel && !in_region(m_lvl, int'(cmd_addr));
          default: ok = m_wel && (m_lvl == 0);
        endcase
        if (ok) begin
          m_grant = 1 << op;
          m_left  = op_len(op);
          if (op == 0) begin
            m_lvl  = int'(wrsr_data[3:2]);
            m_lock = wrsr_data[7];
          end
        end else begin
          m_deny = 1 << op;
          m_wel  = 0;
        end
      end else if (cmd_wren) m_wel = 1;
      else if (cmd_wrdi) m_wel = 0;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (live) begin
      check("R1", "spare bits", int'(status[6:4]), 0);
      check("R4", "busy bit", int'(status[0]), int'(m_left > 0));
      check("R2", "latch bit", int'(status[1]), int'(m_wel));
      check("R8", "level bits", int'(status[3:2]), m_lvl);
      check("R8", "lock bit", int'(status[7]), int'(m_lock));
      check("R3", "grant vector", int'(op_grant), m_grant);
      check("R3", "deny vector", int'(op_deny), m_deny);
    end
  end

  // stimulus helpers: drive on a falling edge, release on the next
  task automatic clear_cmds();
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0;
    cmd_pp = 0; cmd_se = 0; cmd_be = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_cmds();
  endtask

  task automatic wren(); cmd_wren = 1; step(); endtask
  task automatic wrdi(); cmd_wrdi = 1; step(); endtask
  task automatic wrsr(logic [7:0] d); cmd_wrsr = 1; wrsr_data = d; step(); endtask
  task automatic pp(int a); cmd_pp = 1; cmd_addr = ADDR_W'(a); step(); endtask
  task automatic se(int a); cmd_se = 1; cmd_addr = ADDR_W'(a); step(); endtask
  task automatic be(); cmd_be = 1; step(); endtask

  task automatic wait_idle();
    while (status[0]) @(negedge clk);
  endtask

  initial begin
    int busy_cycles;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    live = 1;
    check("R1", "reset status", int'(status), 0);
    check("R1", "reset grant", int'(op_grant), 0);

    pp(0);
    check("R3", "program without latch denied", int'(op_deny), 4'b0010);
    check("R3", "no busy on deny", int'(status[0]), 0);

    wren();
    check("R2", "latch set", int'(status[1]), 1);
    wrdi();
    check("R2", "latch cleared", int'(status[1]), 0);

    wren(); pp(0);
    check("R4", "program granted", int'(op_grant), 4'b0010);
    busy_cycles = 0;
    while (status[0]) begin
      busy_cycles++;
      check("R4", "latch held while busy", int'(status[1]), 1);
      @(negedge clk);
    end
    check("R4", "program busy length", busy_cycles, PP_CYC);
    check("R4", "latch cleared at end", int'(status[1]), 0);

    wren(); wrsr(8'h84);
    check("R8", "status write granted", int'(op_grant), 4'b0001);
    check("R8", "lock and level loaded", int'(status & 8'h8C), 8'h84);
    wait_idle();

    wren(); pp(MEM_SZ - 1);
    check("R6", "top quarter program denied", int'(op_deny), 4'b0010);
    check("R5", "latch dropped on deny", int'(status[1]), 0);
    check("R5", "no busy on deny", int'(status[0]), 0);
    wren(); pp(MEM_SZ / 2);
    check("R6", "below top quarter granted", int'(op_grant), 4'b0010);
    wait_idle();

    wren(); be();
    check("R7", "full erase denied at level 01", int'(op_deny), 4'b1000);

    wp_n = 0;
    wren(); wrsr(8'h00);
    check("R9", "locked status write denied", int'(op_deny), 4'b0001);
    check("R9", "lock and level kept", int'(status & 8'h8C), 8'h84);
    wp_n = 1;
    wren(); wrsr(8'h08);
    check("R9", "pin high allows write", int'(op_grant), 4'b0001);
    wait_idle();
    wp_n = 0;
    wren(); wrsr(8'h0C);
    check("R9", "lock clear allows write with pin low", int'(op_grant), 4'b0001);
    wp_n = 1;
    wait_idle();
    wren(); wrsr(8'h08);
    wait_idle();

    wren(); se(MEM_SZ / 2);
    check("R6", "half level sector erase denied", int'(op_deny), 4'b0100);
    wren(); se(MEM_SZ / 2 - 1);
    check("R6", "lower half erase granted", int'(op_grant), 4'b0100);
    wrdi();
    check("R10", "disable ignored while busy", int'(status[1]), 1);
    pp(0);
    check("R10", "request denied while busy", int'(op_deny), 4'b0010);
    check("R10", "latch kept while busy", int'(status[1]), 1);
    wait_idle();

    wren(); wrsr(8'h7F);
    check("R8", "only level bits taken", int'(status[7:2]), 6'b000011);
    wait_idle();
    wren(); pp(0);
    check("R6", "level 11 protects address 0", int'(op_deny), 4'b0010);
    wren(); wrsr(8'h00);
    wait_idle();

    cmd_wren = 1; cmd_pp = 1; cmd_addr = '0; step();
    check("R11", "program beats enable", int'(op_deny), 4'b0010);
    check("R11", "enable not applied", int'(status[1]), 0);
    wren();
    cmd_pp = 1; cmd_se = 1; cmd_addr = '0; step();
    check("R11", "program beats sector erase", int'(op_grant), 4'b0010);
    wait_idle();
    wren(); be();
    check("R7", "full erase granted at level 00", int'(op_grant), 4'b1000);
    wait_idle();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule